// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the device-side control front end of an asynchronous parallel NOR flash, built as synchronous logic that samples the external control pins on a system clock. It turns the chip enable, output enable, write enable, hardware reset, width select and write-protect pins into one bus operation: standby, read, write, output disable or reset. It drives the 16 data pins through per-bit output enables.

A read fetches a 16-bit word from the storage array, which sits outside the block behind a read-address output and a read-data input. In 8-bit configuration the top data pin stops carrying data and instead supplies the least significant byte-address bit. That bit selects which half of the array word appears on the low eight pins. A write is captured into a command register together with its address and data. The register is handed to the command interpreter with a one-cycle strobe. Writes that land in either outermost boot sector are suppressed while write-protect is asserted, and each such suppression raises a one-cycle flag.

Top module: `pflash_bus_front`

## Requirements
- R1: While the hardware reset pin is low, `bus_op` is 4 (reset) and every `dq_oe` bit is 0. A write that is in progress when reset asserts produces neither `cmd_valid` nor `wp_hit`.
- R2: With `hw_rst_n` high and `chip_en_n` high, `bus_op` is 0 (standby) and `dq_oe` is 0, whatever the output and write enables are.
- R3: With chip enable low and output enable high and write enable high, `bus_op` is 3 (output disable) and `dq_oe` is 0. Chip enable, output enable and write enable all low also gives 3, and entering and leaving that state from standby never produces `cmd_valid`.
- R4: Read, meaning chip enable low, output enable low and write enable high, gives `bus_op` 1. With `x16_sel` = 1 (16-bit configuration), `dq_oe` is 16'hFFFF, `dq_out` equals `rd_data`, and `rd_addr` equals `addr`.
- R5: A read with `x16_sel` = 0 (8-bit configuration) gives `dq_oe` = 16'h00FF, with bits 15..8 of `dq_out` at 0. `dq_out[7:0]` is `rd_data[7:0]` when `dq_in[15]` is 0 and `rd_data[15:8]` when it is 1.
- R6: Chip enable low, write enable low and output enable high give `bus_op` 2 and `dq_oe` 0. When the write ends, whether write enable or chip enable rises first, `cmd_valid` pulses for exactly one cycle with `cmd_addr` equal to `addr`.
- R7: In 16-bit configuration a write yields `cmd_data` = `dq_in`, `cmd_lsb` = 0 and `cmd_byte` = 0. In 8-bit configuration it yields `cmd_data` = {8'h00, `dq_in[7:0]`}, `cmd_lsb` = `dq_in[15]` and `cmd_byte` = 1.
- R8: When `prot_n` is low during a write whose sector index `addr[20:15]` is 0 or 63, no `cmd_valid` is issued. Instead `wp_hit` pulses for one cycle in the cycle the strobe would have appeared.
- R9: A write with `prot_n` low to a sector other than 0 or 63, or with `prot_n` high to any sector, is passed on normally with `cmd_valid` and no `wp_hit`.
- R10: Each control pin passes through a two-flop synchroniser. A pin change made between two rising edges shows on `dq_oe` and `dq_out` after the third following rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| chip_en_n | input | 1 | Chip enable pin, active low |
| out_en_n | input | 1 | Output enable pin, active low |
| wr_en_n | input | 1 | Write enable pin, active low |
| x16_sel | input | 1 | 1 = 16-bit configuration, 0 = 8-bit configuration |
| prot_n | input | 1 | Boot-sector write protect, active low |
| addr | input | 21 | Word address pins |
| dq_in | input | 16 | Data pins, input side (bit 15 is the byte-address bit in 8-bit mode) |
| dq_out | output | 16 | Data pins, output side |
| dq_oe | output | 16 | Per-bit output enable of the data pins |
| rd_addr | output | 21 | Word address to the storage array |
| rd_data | input | 16 | Word read from the storage array |
| bus_op | output | 3 | Decoded operation: 0 standby, 1 read, 2 write, 3 output disable, 4 reset |
| cmd_valid | output | 1 | One-cycle strobe for a completed, accepted write |
| cmd_addr | output | 21 | Word address of the captured write |
| cmd_lsb | output | 1 | Byte-address bit of the captured write |
| cmd_data | output | 16 | Data of the captured write |
| cmd_byte | output | 1 | Captured write was made in 8-bit configuration |
| wp_hit | output | 1 | One-cycle flag: a write was suppressed by write protect |

## Verification
The hardest case to reach from the pins is a write that is cut off by the hardware reset pin while write enable and chip enable are still low. In that case the block must discard the half-captured command rather than emit it when the enables later rise. The stimulus opens a write, waits for it to be decoded, pulls reset low, releases both enables while reset is still held, and only then lets reset go. It then confirms that neither the strobe nor the protect flag ever appeared. The boot-sector boundary is reached by aiming protected writes at the first and the last sector index and at a middle one, and the latency claim is pinned by sampling the output enables after exactly two and exactly three edges.

// File: rtl/pflash_bus_front.sv
module pflash_bus_front #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int SECT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic              x16_sel,
  input  logic              prot_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [2:0]        bus_op,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_lsb,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_byte,
  output logic              wp_hit
);
  localparam int HALF = DATA_W / 2;
  localparam int SIDX_W = ADDR_W - SECT_W;
  localparam logic [2:0] OP_STBY = 3'd0;
  localparam logic [2:0] OP_RD   = 3'd1;
  localparam logic [2:0] OP_WR   = 3'd2;
  localparam logic [2:0] OP_OD   = 3'd3;
  localparam logic [2:0] OP_RST  = 3'd4;

  // synchroniser order: {hw_rst_n, chip_en_n, out_en_n, wr_en_n, x16_sel, prot_n}
  logic [5:0] sync1, sync2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 6'b011111;
      sync2 <= 6'b011111;
    end else begin
      sync1 <= {hw_rst_n, chip_en_n, out_en_n, wr_en_n, x16_sel, prot_n};
      sync2 <= sync1;
    end

  logic s_rst_n, s_ce_n, s_oe_n, s_we_n, s_word, s_prot_n;
  assign {s_rst_n, s_ce_n, s_oe_n, s_we_n, s_word, s_prot_n} = sync2;

  logic [2:0] op;
  always_comb
    if (!s_rst_n)               op = OP_RST;
    else if (s_ce_n)            op = OP_STBY;
    else if (!s_we_n && s_oe_n) op = OP_WR;
    else if (!s_oe_n && s_we_n) op = OP_RD;
    else                        op = OP_OD;
  assign bus_op  = op;
  assign rd_addr = addr;

  logic [HALF-1:0] byte_sel;
  assign byte_sel = dq_in[DATA_W-1] ? rd_data[DATA_W-1:HALF] : rd_data[HALF-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
    end else if (op == OP_RD && s_word) begin
      dq_out <= rd_data;
      dq_oe  <= '1;
    end else if (op == OP_RD) begin
      dq_out <= {{HALF{1'b0}}, byte_sel};
      dq_oe  <= {{HALF{1'b0}}, {HALF{1'b1}}};
    end else begin
      dq_out <= '0;
      dq_oe  <= '0;
    end

  logic              w_act, w_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              hold_lsb, hold_byte, hold_prot_n;
  assign w_act = (op == OP_WR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w_q         <= 1'b0;
      hold_addr   <= '0;
      hold_data   <= '0;
      hold_lsb    <= 1'b0;
      hold_byte   <= 1'b0;
      hold_prot_n <= 1'b1;
    end else begin
      w_q <= w_act;
      if (w_act) begin
        hold_addr   <= addr;
        hold_data   <= s_word ? dq_in : {{HALF{1'b0}}, dq_in[HALF-1:0]};
        hold_lsb    <= s_word ? 1'b0 : dq_in[DATA_W-1];
        hold_byte   <= !s_word;
        hold_prot_n <= s_prot_n;
      end
    end

  logic [SIDX_W-1:0] sidx;
  logic boot, fin, blocked;
  assign sidx    = hold_addr[ADDR_W-1:SECT_W];
  assign boot    = (sidx == '0) || (sidx == '1);
  assign fin     = w_q && !w_act && (op != OP_RST);
  assign blocked = boot && !hold_prot_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      wp_hit    <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_lsb   <= 1'b0;
      cmd_byte  <= 1'b0;
    end else begin
      cmd_valid <= fin && !blocked;
      wp_hit    <= fin && blocked;
      if (fin && !blocked) begin
        cmd_addr <= hold_addr;
        cmd_data <= hold_data;
        cmd_lsb  <= hold_lsb;
        cmd_byte <= hold_byte;
      end
    end

  AST_RESET_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_RST) |=> (dq_oe == '0)); // R1
  AST_RESET_ABANDON: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_RST) |=> (!cmd_valid && !wp_hit)); // R1
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (op != OP_RD) |=> (dq_oe == '0)); // R2
  AST_BYTE_UPPER_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (op == OP_RD && !s_word) |=> (dq_oe[DATA_W-1:HALF] == '0)); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R6
  AST_WP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_valid && wp_hit)); // R8
  AST_WP_BOOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n) wp_hit |-> ($past(sidx) == '0 || $past(sidx) == '1)); // R8
endmodule

// File: tb/test_pflash_bus_front.sv
`timescale 1ns/1ps
module test_pflash_bus_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_rst_n, chip_en_n, out_en_n, wr_en_n, x16_sel, prot_n;
  logic [20:0] addr;
  logic [15:0] dq_in, dq_out, dq_oe, rd_data, cmd_data;
  logic [20:0] rd_addr, cmd_addr;
  logic [2:0]  bus_op;
  logic        cmd_valid, cmd_lsb, cmd_byte, wp_hit;

  always #4 clk = ~clk;

  pflash_bus_front i_pflash_bus_front (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .x16_sel(x16_sel), .prot_n(prot_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_op(bus_op),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_lsb(cmd_lsb),
    .cmd_data(cmd_data), .cmd_byte(cmd_byte), .wp_hit(wp_hit));

  // array model
  assign rd_data = {rd_addr[7:0] ^ 8'h5A, rd_addr[15:8] ^ 8'hC3};

  int n_chk = 0, n_bad = 0, n_cmd = 0, n_wp = 0;
  logic [20:0] m_addr;
  logic [15:0] m_data;
  logic        m_lsb, m_byte;

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++;
      m_addr = cmd_addr; m_data = cmd_data; m_lsb = cmd_lsb; m_byte = cmd_byte;
    end
    if (wp_hit) n_wp++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_word(input logic [20:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  task automatic bus_idle();
    chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
    idle(5);
  endtask

  task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic word,
                          input logic prot, input logic ce_first);
    addr = a; dq_in = d; x16_sel = word; prot_n = prot;
    idle(5);
    chip_en_n = 1'b0; wr_en_n = 1'b0;
    idle(5);
    if (ce_first) chip_en_n = 1'b1; else wr_en_n = 1'b1;
    idle(5);
    bus_idle();
  endtask

  task automatic t_reset_state();
    check("R1 reset op", bus_op, 3'd4);
    check("R1 reset oe", dq_oe, 16'h0000);
    check("R1 reset strobe", cmd_valid, 1'b0);
  endtask

  task automatic t_standby();
    chip_en_n = 1'b1; out_en_n = 1'b0; wr_en_n = 1'b0;
    idle(5);
    check("R2 standby op", bus_op, 3'd0);
    check("R2 standby oe", dq_oe, 16'h0000);
    bus_idle();
  endtask

  task automatic t_outdis();
    int c0 = n_cmd;
    chip_en_n = 1'b0;
    idle(5);
    check("R3 outdis op", bus_op, 3'd3);
    check("R3 outdis oe", dq_oe, 16'h0000);
    chip_en_n = 1'b1; idle(3);
    chip_en_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b0;
    idle(5);
    check("R3 all-low op", bus_op, 3'd3);
    check("R3 all-low oe", dq_oe, 16'h0000);
    bus_idle();
    check("R3 all-low no strobe", n_cmd, c0);
  endtask

  task automatic t_read_word();
    x16_sel = 1'b1; addr = 21'h0A1B2C;
    chip_en_n = 1'b0; out_en_n = 1'b0;
    idle(5);
    check("R4 read op", bus_op, 3'd1);
    check("R4 read oe", dq_oe, 16'hFFFF);
    check("R4 read data", dq_out, exp_word(21'h0A1B2C));
    check("R4 rd_addr", rd_addr, 21'h0A1B2C);
    addr = 21'h1F00FF; idle(2);
    check("R4 read data 2", dq_out, exp_word(21'h1F00FF));
    bus_idle();
  endtask

  task automatic t_read_byte();
    logic [15:0] w;
    x16_sel = 1'b0; addr = 21'h003456; dq_in = 16'h0000;
    w = exp_word(21'h003456);
    chip_en_n = 1'b0; out_en_n = 1'b0;
    idle(5);
    check("R5 byte oe", dq_oe, 16'h00FF);
    check("R5 even byte", dq_out, {8'h00, w[7:0]});
    dq_in = 16'h8000; idle(2);
    check("R5 odd byte", dq_out, {8'h00, w[15:8]});
    bus_idle();
    x16_sel = 1'b1; dq_in = 16'h0000;
  endtask

  task automatic t_latency();
    x16_sel = 1'b1; addr = 21'h000777;
    idle(3);
    chip_en_n = 1'b0; out_en_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 two edges", dq_oe, 16'h0000);
    @(negedge clk);
    check("R10 three edges", dq_oe, 16'hFFFF);
    bus_idle();
  endtask

  task automatic t_write_word();
    int c0 = n_cmd;
    addr = 21'h0ABCDE; dq_in = 16'hBEEF; x16_sel = 1'b1; prot_n = 1'b1;
    idle(5);
    chip_en_n = 1'b0; wr_en_n = 1'b0;
    idle(5);
    check("R6 write op", bus_op, 3'd2);
    check("R6 write oe", dq_oe, 16'h0000);
    wr_en_n = 1'b1;
    idle(5);
    check("R6 one strobe", n_cmd, c0 + 1);
    check("R6 cmd addr", m_addr, 21'h0ABCDE);
    check("R7 word data", m_data, 16'hBEEF);
    check("R7 word lsb", m_lsb, 1'b0);
    check("R7 word flag", m_byte, 1'b0);
    bus_idle();
    do_write(21'h054321, 16'h1234, 1'b1, 1'b1, 1'b1);
    check("R6 ce-ended strobe", n_cmd, c0 + 2);
    check("R6 ce-ended addr", m_addr, 21'h054321);
  endtask

  task automatic t_write_byte();
    int c0 = n_cmd;
    do_write(21'h012345, 16'h803C, 1'b0, 1'b1, 1'b0);
    check("R7 byte strobe", n_cmd, c0 + 1);
    check("R7 byte addr", m_addr, 21'h012345);
    check("R7 byte data", m_data, 16'h003C);
    check("R7 byte lsb", m_lsb, 1'b1);
    check("R7 byte flag", m_byte, 1'b1);
    x16_sel = 1'b1;
  endtask

  task automatic t_protect();
    int c0 = n_cmd, w0 = n_wp;
    do_write(21'h000010, 16'hAAAA, 1'b1, 1'b0, 1'b0);
    check("R8 sector 0 blocked", n_cmd, c0);
    check("R8 sector 0 flag", n_wp, w0 + 1);
    do_write(21'h1F8000, 16'h5555, 1'b1, 1'b0, 1'b0);
    check("R8 sector 63 blocked", n_cmd, c0);
    check("R8 sector 63 flag", n_wp, w0 + 2);
    do_write(21'h100000, 16'h0F0F, 1'b1, 1'b0, 1'b0);
    check("R9 middle passes", n_cmd, c0 + 1);
    check("R9 middle addr", m_addr, 21'h100000);
    do_write(21'h000010, 16'hF0F0, 1'b1, 1'b1, 1'b0);
    check("R9 unprotected boot passes", n_cmd, c0 + 2);
    check("R9 unprotected boot data", m_data, 16'hF0F0);
    check("R9 no extra flag", n_wp, w0 + 2);
    prot_n = 1'b1;
  endtask

  task automatic t_abandon();
    int c0 = n_cmd, w0 = n_wp;
    addr = 21'h000020; dq_in = 16'h7777; prot_n = 1'b0;
    idle(5);
    chip_en_n = 1'b0; wr_en_n = 1'b0;
    idle(5);
    hw_rst_n = 1'b0;
    idle(5);
    check("R1 reset during write op", bus_op, 3'd4);
    check("R1 reset during write oe", dq_oe, 16'h0000);
    wr_en_n = 1'b1; chip_en_n = 1'b1;
    idle(5);
    hw_rst_n = 1'b1;
    idle(5);
    check("R1 abandoned strobe", n_cmd, c0);
    check("R1 abandoned flag", n_wp, w0);
    prot_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hw_rst_n = 1'b1; chip_en_n = 1'b1; out_en_n = 1'b1;
    wr_en_n = 1'b1; x16_sel = 1'b1; prot_n = 1'b1; addr = '0; dq_in = '0;
    idle(3);
    t_reset_state();
    rst_n = 1'b1;
    idle(5);
    t_standby();
    t_outdis();
    t_read_word();
    t_read_byte();
    t_latency();
    t_write_word();
    t_write_byte();
    t_protect();
    t_abandon();
    finish_run();
  end
endmodule